// File: doc/BRIEF.md
# Raster Scanline Counter with Line-Compare Interrupt

This block keeps the current display line number of a raster video unit. A dot-rate clock enable drives an internal dot counter; each time a full line of dots has gone by, the line number steps up by one. After the last line of the frame it falls back to zero. Counting runs only while the display is switched on. Any write to the control input with the display-on bit set puts both the line number and the dot counter back to zero.

Software loads a line-compare value through a write strobe. The block keeps a coincidence flag that is high whenever the line number equals the compare value. The flag is updated when the line number changes and also when the compare value is rewritten. When the compare interrupt enable is high, the block emits a single-cycle interrupt request each time the gated coincidence condition turns true. A write port for the line number is present on the register bus, but the block ignores it because the line number is read-only.

The dots per line, the lines per frame and the width of the line register are parameters. Their defaults are 456 dots, 154 lines and 8 bits.

Top module: `raster_line_tracker`

## Requirements
- R1: While the display is on, the line number goes up by exactly one after DOTS_PER_LINE clock cycles in which dot_en is high. Cycles with dot_en low do not count.
- R2: When line LINES_PER_FRAME-1 completes, the line number returns to 0. line_o never reaches LINES_PER_FRAME or higher.
- R3: From reset onward, coinc_o equals (line_o == cmp_value_o) on every cycle.
- R4: irq_o is high for one cycle when the condition (coincidence AND cmp_irq_en) goes from false to true. It stays low while that condition remains true.
- R5: irq_o stays low in every cycle that follows a clock edge at which cmp_irq_en was low.
- R6: A cmp_wr write loads cmp_wdata into cmp_value_o at the next edge. coinc_o is re-evaluated against the current line at that same edge, even if the line number does not change.
- R7: A ctrl_wr write with ctrl_disp_on=1 clears the line number and the dot counter at the next edge, whatever state they were in, and switches the display on.
- R8: A ctrl_wr write with ctrl_disp_on=0 switches the display off. The line number then holds its value whatever dot_en does.
- R9: Writes on line_wr/line_wdata have no effect on line_o or on any other output.
- R10: After reset, line_o=0, cmp_value_o=0, coinc_o=1, irq_o=0, and the display is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | One pulse per dot period |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_disp_on | input | 1 | Display-on bit of the control write |
| cmp_wr | input | 1 | Write strobe for the line-compare value |
| cmp_wdata | input | LINE_W | Line-compare value to load |
| line_wr | input | 1 | Write strobe to the line register (ignored) |
| line_wdata | input | LINE_W | Write data to the line register (ignored) |
| cmp_irq_en | input | 1 | Enables the compare interrupt |
| line_o | output | LINE_W | Current line number |
| cmp_value_o | output | LINE_W | Current line-compare value |
| coinc_o | output | 1 | Line number equals compare value |
| irq_o | output | 1 | Single-cycle compare interrupt request |

## Verification
The assertions check four things on every cycle: that the line number stays in range and moves only by +1 or back to zero, that the coincidence flag matches the two visible register values, and that an interrupt pulse lasts one cycle, occurs only with coincidence, and occurs only after the enable was sampled high. The bench scenarios are needed for the rest: the exact number of dot enables per line, the clear caused by a control write, the freeze while the display is off, that the ignored line write has no effect, and the exact number of interrupt pulses per frame. The bench checks these on a reduced frame of 5 dots by 12 lines, against a reference model updated from the requirements and against closed-form line arithmetic.

// File: rtl/raster_line_pkg.sv
package raster_line_pkg;

   // what the line/dot counter does on a given cycle
   typedef enum logic [1:0] {
      STEP_HOLD    = 2'd0,
      STEP_DOT     = 2'd1,
      STEP_NEWLINE = 2'd2,
      STEP_CLEAR   = 2'd3
   } line_step_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/raster_line_counter.sv
module raster_line_counter
   import raster_line_pkg::*;
#(
   parameter int unsigned DOTS_PER_LINE   = 456,
   parameter int unsigned LINES_PER_FRAME = 154,
   parameter int unsigned LINE_W          = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              ctrl_wr,
   input  logic              ctrl_disp_on,
   output logic [LINE_W-1:0] line_q_o,
   output logic [LINE_W-1:0] line_d_o
);

   localparam int unsigned       DOT_W     = bits_for(DOTS_PER_LINE);
   localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
   localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FRAME - 1);

   if (DOTS_PER_LINE < 2) begin : g_bad_dots
      $error("raster_line_counter: DOTS_PER_LINE must be at least 2");
   end
   if (LINES_PER_FRAME < 2 || LINES_PER_FRAME > (1 << LINE_W)) begin : g_bad_lines
      $error("raster_line_counter: LINES_PER_FRAME must fit in LINE_W bits");
   end

   logic [DOT_W-1:0]  dot_q, dot_d;
   logic [LINE_W-1:0] line_q, line_d, line_inc;
   logic              disp_q, disp_d;
   line_step_e        step;

   // wrap variant: free overflow when the frame fills the register
   if (LINES_PER_FRAME == (1 << LINE_W)) begin : g_wrap_pow2
      assign line_inc = line_q + 1'b1;
   end else begin : g_wrap_cmp
      assign line_inc = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
   end

   always_comb begin
      if (ctrl_wr && ctrl_disp_on) begin
         step = STEP_CLEAR;
      end else if (disp_q && dot_en) begin
         step = (dot_q == DOT_LAST) ? STEP_NEWLINE : STEP_DOT;
      end else begin
         step = STEP_HOLD;
      end
   end

   always_comb begin
      dot_d  = dot_q;
      line_d = line_q;
      unique case (step)
         STEP_CLEAR: begin
            dot_d  = '0;
            line_d = '0;
         end
         STEP_NEWLINE: begin
            dot_d  = '0;
            line_d = line_inc;
         end
         STEP_DOT: begin
            dot_d = dot_q + 1'b1;
         end
         default: begin
            dot_d  = dot_q;
            line_d = line_q;
         end
      endcase
   end

   assign disp_d = ctrl_wr ? ctrl_disp_on : disp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dot_q  <= '0;
         line_q <= '0;
         disp_q <= 1'b0;
      end else begin
         dot_q  <= dot_d;
         line_q <= line_d;
         disp_q <= disp_d;
      end
   end

   assign line_q_o = line_q;
   assign line_d_o = line_d;

endmodule

// File: rtl/raster_line_compare.sv
module raster_line_compare #(
   parameter int unsigned LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_wr,
   input  logic [LINE_W-1:0] cmp_wdata,
   input  logic [LINE_W-1:0] line_d_i,
   output logic [LINE_W-1:0] cmp_q_o,
   output logic              coinc_d_o,
   output logic              coinc_q_o
);

   logic [LINE_W-1:0] cmp_q, cmp_d;
   logic              coinc_q;

   assign cmp_d     = cmp_wr ? cmp_wdata : cmp_q;
   // compare next-state values so flag, line and compare value change together
   assign coinc_d_o = (line_d_i == cmp_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q   <= '0;
         coinc_q <= 1'b1;
      end else begin
         cmp_q   <= cmp_d;
         coinc_q <= coinc_d_o;
      end
   end

   assign cmp_q_o   = cmp_q;
   assign coinc_q_o = coinc_q;

endmodule

// File: rtl/raster_line_irq.sv
module raster_line_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic coinc_d_i,
   input  logic irq_en_i,
   output logic irq_o
);

   logic cond_d, cond_q, irq_q;

   assign cond_d = coinc_d_i & irq_en_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         cond_q <= cond_d;
         irq_q  <= cond_d & ~cond_q;
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/raster_line_tracker.sv
module raster_line_tracker #(
   parameter int unsigned DOTS_PER_LINE   = 456,
   parameter int unsigned LINES_PER_FRAME = 154,
   parameter int unsigned LINE_W          = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              ctrl_wr,
   input  logic              ctrl_disp_on,
   input  logic              cmp_wr,
   input  logic [LINE_W-1:0] cmp_wdata,
   input  logic              line_wr,
   input  logic [LINE_W-1:0] line_wdata,
   input  logic              cmp_irq_en,
   output logic [LINE_W-1:0] line_o,
   output logic [LINE_W-1:0] cmp_value_o,
   output logic              coinc_o,
   output logic              irq_o
);

   logic [LINE_W-1:0] line_d;
   logic              coinc_d;

   // the line register is read-only; bus writes are dropped here
   logic unused_line_write;
   assign unused_line_write = line_wr ^ (^line_wdata);

   raster_line_counter #(
      .DOTS_PER_LINE  (DOTS_PER_LINE),
      .LINES_PER_FRAME(LINES_PER_FRAME),
      .LINE_W         (LINE_W)
   ) counter_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dot_en      (dot_en),
      .ctrl_wr     (ctrl_wr),
      .ctrl_disp_on(ctrl_disp_on),
      .line_q_o    (line_o),
      .line_d_o    (line_d)
   );

   raster_line_compare #(
      .LINE_W(LINE_W)
   ) compare_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_wr   (cmp_wr),
      .cmp_wdata(cmp_wdata),
      .line_d_i (line_d),
      .cmp_q_o  (cmp_value_o),
      .coinc_d_o(coinc_d),
      .coinc_q_o(coinc_o)
   );

   raster_line_irq irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .coinc_d_i(coinc_d),
      .irq_en_i (cmp_irq_en),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/raster_line_tracker_chk.sv
module raster_line_tracker_chk #(
   parameter int unsigned LINES_PER_FRAME = 154,
   parameter int unsigned LINE_W          = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_irq_en,
   input logic [LINE_W-1:0] line_o,
   input logic [LINE_W-1:0] cmp_value_o,
   input logic              coinc_o,
   input logic              irq_o
);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   a_r2_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(line_o) < int'(LINES_PER_FRAME));

   a_r3_coinc_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      coinc_o == (line_o == cmp_value_o));

   a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && (line_o != $past(line_o))) |->
         ((int'(line_o) == int'($past(line_o)) + 1) || (line_o == '0)));

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   a_r4_pulse_on_coinc: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> coinc_o);

   a_r5_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && irq_o) |-> $past(cmp_irq_en));

endmodule

bind raster_line_tracker raster_line_tracker_chk #(
   .LINES_PER_FRAME(LINES_PER_FRAME),
   .LINE_W         (LINE_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmp_irq_en (cmp_irq_en),
   .line_o     (line_o),
   .cmp_value_o(cmp_value_o),
   .coinc_o    (coinc_o),
   .irq_o      (irq_o)
);

// File: tb/raster_line_tracker_tb.sv
module raster_line_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int B_DOTS     = 5;
   localparam int B_LINES    = 12;
   localparam int LW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dot_en = 1'b0, ctrl_wr = 1'b0, ctrl_disp_on = 1'b0;
   logic          cmp_wr = 1'b0, line_wr = 1'b0, cmp_irq_en = 1'b0;
   logic [LW-1:0] cmp_wdata = '0, line_wdata = '0;
   logic [LW-1:0] line_o, cmp_value_o;
   logic          coinc_o, irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   int pulses   = 0;
   bit finished = 0;

   // reference state from the requirements
   int m_line = 0, m_dot = 0, m_cmp = 0;
   bit m_disp = 0, m_coinc = 1, m_cond = 0, m_irq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   raster_line_tracker #(
      .DOTS_PER_LINE  (B_DOTS),
      .LINES_PER_FRAME(B_LINES),
      .LINE_W         (LW)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dot_en      (dot_en),
      .ctrl_wr     (ctrl_wr),
      .ctrl_disp_on(ctrl_disp_on),
      .cmp_wr      (cmp_wr),
      .cmp_wdata   (cmp_wdata),
      .line_wr     (line_wr),
      .line_wdata  (line_wdata),
      .cmp_irq_en  (cmp_irq_en),
      .line_o      (line_o),
      .cmp_value_o (cmp_value_o),
      .coinc_o     (coinc_o),
      .irq_o       (irq_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   // one cycle: drive at negedge, advance model at posedge, compare at next negedge
   task automatic tick(input bit de, input bit cw, input bit con,
                       input bit yw, input int ywd,
                       input bit lw, input int lwd, input bit ie);
      bit cond_n;
      dot_en = de; ctrl_wr = cw; ctrl_disp_on = con;
      cmp_wr = yw; cmp_wdata = LW'(ywd);
      line_wr = lw; line_wdata = LW'(lwd);
      cmp_irq_en = ie;
      @(posedge clk);
      if (cw && con) begin
         m_line = 0; m_dot = 0;
      end else if (m_disp && de) begin
         if (m_dot == B_DOTS - 1) begin
            m_dot  = 0;
            m_line = (m_line + 1) % B_LINES;
         end else begin
            m_dot++;
         end
      end
      if (cw) m_disp = con;
      if (yw) m_cmp = ywd % (1 << LW);
      m_coinc = (m_line == m_cmp);
      cond_n  = m_coinc && ie;
      m_irq   = cond_n && !m_cond;
      m_cond  = cond_n;
      @(negedge clk);
      if (irq_o) pulses++;
      check("R1/R2 line", int'(line_o), m_line);
      check("R6 cmp value", int'(cmp_value_o), m_cmp);
      check("R3 coinc", int'(coinc_o), int'(m_coinc));
      check("R4/R5 irq", int'(irq_o), int'(m_irq));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 line", int'(line_o), 0);
      check("R10 cmp", int'(cmp_value_o), 0);
      check("R10 coinc", int'(coinc_o), 1);
      check("R10 irq", int'(irq_o), 0);
      rst_n = 1'b1;
      // R10: display off after reset, dot enables do nothing
      for (int i = 0; i < 12; i++) tick(1, 0, 0, 0, 0, 0, 0, 0);
      check("R10 display off", int'(line_o), 0);

      // R7 enable display, R6 set compare to 3
      tick(0, 1, 1, 1, 3, 0, 0, 0);
      // R1/R2 continuous enables, interrupt disabled (R5)
      pulses = 0;
      for (int i = 0; i < 150; i++) tick(1, 0, 0, 0, 0, 0, 0, 0);
      check("R1 closed form", int'(line_o), (150 / B_DOTS) % B_LINES);
      check("R5 no pulse when disabled", pulses, 0);

      // R4 interrupt enabled: line 6 -> 3 twice within 130 enables
      pulses = 0;
      for (int i = 0; i < 130; i++) tick(1, 0, 0, 0, 0, 0, 0, 1);
      check("R4 pulses per two frames", pulses, 2);
      check("R2 wrap closed form", int'(line_o), ((280) / B_DOTS) % B_LINES);

      // R1 sparse dot enables: one in three cycles
      base = int'(line_o);
      for (int i = 0; i < 90; i++) tick(i % 3 == 0, 0, 0, 0, 0, 0, 0, 1);
      check("R1 sparse enables", int'(line_o), (base + 30 / B_DOTS) % B_LINES);

      // R6 compare rewritten to the current line: flag and pulse without line change
      tick(0, 0, 0, 1, 200, 0, 0, 1);
      check("R6 mismatch", int'(coinc_o), 0);
      pulses = 0;
      tick(0, 0, 0, 1, int'(line_o), 0, 0, 1);
      check("R6 rematch flag", int'(coinc_o), 1);
      check("R6 rematch pulse", pulses, 1);
      // R4 holds while condition holds: no further pulse
      for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, 0, 0, 1);
      check("R4 no repeat", pulses, 1);

      // R9 writes to the line register are ignored
      base = int'(line_o);
      for (int v = 0; v < 256; v += 17) tick(0, 0, 0, 0, 0, 1, v, 1);
      check("R9 line unchanged", int'(line_o), base);
      for (int v = 0; v < 40; v++) tick(1, 0, 0, 0, 0, 1, v * 7, 1);

      // R7 clear mid-frame
      for (int i = 0; i < 13; i++) tick(1, 0, 0, 0, 0, 0, 0, 0);
      tick(1, 1, 1, 0, 0, 0, 0, 0);
      check("R7 cleared", int'(line_o), 0);
      for (int i = 0; i < B_DOTS - 1; i++) tick(1, 0, 0, 0, 0, 0, 0, 0);
      check("R7 dot counter cleared", int'(line_o), 0);
      tick(1, 0, 0, 0, 0, 0, 0, 0);
      check("R7 first line after clear", int'(line_o), 1);

      // R8 display off freezes the line
      tick(1, 1, 0, 0, 0, 0, 0, 0);
      base = int'(line_o);
      for (int i = 0; i < 40; i++) tick(1, 0, 0, 0, 0, 0, 0, 0);
      check("R8 frozen", int'(line_o), base);
      tick(0, 1, 1, 0, 0, 0, 0, 0);

      // R2/R4 compare at last line: one pulse per frame
      tick(0, 0, 0, 1, B_LINES - 1, 0, 0, 1);
      pulses = 0;
      for (int i = 0; i < B_DOTS * B_LINES; i++) tick(1, 0, 0, 0, 0, 0, 0, 1);
      check("R2 last-line pulse", pulses, 1);

      // R3 out-of-range compare never matches
      tick(0, 0, 0, 1, 200, 0, 0, 1);
      pulses = 0;
      for (int i = 0; i < B_DOTS * B_LINES; i++) tick(1, 0, 0, 0, 0, 0, 0, 1);
      check("R3 no match beyond frame", pulses, 0);

      finish_run();
   end

endmodule